// File: doc/BRIEF.md
# Thermometer Element Scrambler for a Unary Capacitor Segment

This block drives the switch enables of the unary part of a charge-redistribution SAR converter's capacitor array. The three most significant bits of the conversion are not built as binary-weighted capacitors. Each of them is built from identical unit elements, so the three bits together control seven equal elements. The block takes the decisions for those three bits as the successive-approximation loop resolves them, highest first. It turns the partial code into a thermometer word of ones, then rotates that word by an offset so that the set of physical elements in use changes from one conversion to the next. Over many conversions, the element-to-element mismatch averages out instead of showing up as a fixed nonlinearity.

The rotation offset comes from a 15-bit maximal-length shift register. The register advances once for every conversion-start strobe, and the block takes the offset from its low three bits, folded into the range 0..6. The offset is captured at the start strobe and held for the whole conversion. Enables already switched on for an earlier decision therefore stay on the same elements while the later decisions arrive. Before each enable word is registered, a population-count check compares it with the code. If the two do not match, the block drives no element and raises a flag.

Top module: `dem_therm_scrambler`

## Requirements
- R1: While reset is asserted and in the first cycle after it, all seven element enables are 0 and `check_fail` is 0. The shift register state after reset is the seed 15'h0001.
- R2: The number of ones in `elem_en` always equals the binary value of the top-bit code resolved so far in the current conversion.
- R3: Each `conv_start` cycle advances the shift register one step: the next state is {s[13:0], s[14]^s[13]} (taps x^15 + x^14 + 1). The raw offset for the conversion is bits [2:0] of the advanced state.
- R4: With offset k, `elem_en` bit (i+k) mod 7 equals 1 exactly when i is less than the code value, for i in 0..6.
- R5: Decisions arrive on `dec_bit` qualified by `dec_valid`. The first one after a start is code bit 2 (weight 4), the second is bit 1 (weight 2), and the third is bit 0 (weight 1). `elem_en` reflects each decision in the cycle after it is presented.
- R6: Once three decisions have been taken in a conversion, further `dec_valid` pulses leave `elem_en` unchanged until the next start.
- R7: Within a conversion the offset is held constant, so an enable that is 1 stays 1 until the next `conv_start`. With no strobe and no decision, `elem_en` holds its value.
- R8: In the cycle after `conv_start`, `elem_en` is all zero, because the code is cleared.
- R9: When `conv_start` and `dec_valid` are both high in the same cycle, the start wins and the decision is discarded.
- R10: A raw offset of 7 is folded to offset 0.
- R11: `check_fail` rises only when the count check fails; in that case `elem_en` is forced to zero. On a correct build it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start | input | 1 | One-cycle strobe opening a new conversion |
| dec_valid | input | 1 | A top-bit decision is presented this cycle |
| dec_bit | input | 1 | Value of the presented decision |
| elem_en | output | 7 | Switch enables of the seven unary elements |
| check_fail | output | 1 | Population count of the enables disagreed with the code |

## Verification
Single-element codes (value 1) expose the offset directly, since the one lit element sits at the offset. Over two hundred conversions the bench follows the shift-register sequence. A wrong tap, a missed step, or a step on the wrong event would move that element. The run includes the raw offset of 7: a design that failed to fold it would lose an element through an out-of-range rotation, or would wrap it to the wrong place. The bench also checks the priority of a start strobe over a simultaneous decision, extra decisions after the third, and idle cycles. A design that did not freeze the offset, or that let a late decision rewrite a code bit, would turn off an element that was already on or would leave a stale enable.

// File: rtl/dem_pkg.sv
package dem_pkg;
    // Default geometry of the unary segment and its scrambling source
    localparam int TBITS_DEF  = 3;
    localparam int LFSR_W_DEF = 15;
    localparam int TAP_HI_DEF = 15;
    localparam int TAP_LO_DEF = 14;
    localparam logic [LFSR_W_DEF-1:0] SEED_DEF = 15'h0001;
endpackage

// File: rtl/dem_lfsr_step.sv
// One step of a Fibonacci shift register with two taps (1-based positions).
module dem_lfsr_step #(
    parameter int W      = 15,
    parameter int TAP_HI = 15,
    parameter int TAP_LO = 14
) (
    input  logic [W-1:0] cur,
    output logic [W-1:0] nxt
);
    always_comb begin
        nxt = {cur[W-2:0], cur[TAP_HI-1] ^ cur[TAP_LO-1]};
    end
endmodule

// File: rtl/dem_therm_enc.sv
// Binary code to thermometer word: the lowest `code` positions are set.
module dem_therm_enc #(
    parameter int NBITS = 3,
    localparam int NOUT = (1 << NBITS) - 1
) (
    input  logic [NBITS-1:0] code,
    output logic [NOUT-1:0]  therm
);
    for (genvar i = 0; i < NOUT; i++) begin : g_pos
        assign therm[i] = (int'(code) > i);
    end
endmodule

// File: rtl/dem_rotator.sv
// Circular left rotation: input position i lands on output (i + amt) mod N.
module dem_rotator #(
    parameter int N     = 7,
    parameter int AMT_W = 3
) (
    input  logic [N-1:0]     din,
    input  logic [AMT_W-1:0] amt,
    output logic [N-1:0]     dout
);
    always_comb begin
        dout = '0;
        for (int j = 0; j < N; j++) begin
            int src;
            src = j - int'(amt);
            if (src < 0) src = src + N;
            dout[j] = din[src];
        end
    end
endmodule

// File: rtl/dem_therm_scrambler.sv
module dem_therm_scrambler
    import dem_pkg::*;
#(
    parameter int              TBITS  = TBITS_DEF,
    parameter int              LFSR_W = LFSR_W_DEF,
    parameter int              TAP_HI = TAP_HI_DEF,
    parameter int              TAP_LO = TAP_LO_DEF,
    parameter logic [LFSR_W-1:0] SEED = SEED_DEF,
    localparam int             NUM_ELEM = (1 << TBITS) - 1,
    localparam int             IDX_W    = $clog2(TBITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                conv_start,
    input  logic                dec_valid,
    input  logic                dec_bit,
    output logic [NUM_ELEM-1:0] elem_en,
    output logic                check_fail
);
    typedef struct packed {
        logic [LFSR_W-1:0] lfsr;
        logic [TBITS-1:0]  offset;
        logic [TBITS-1:0]  code;
        logic [IDX_W-1:0]  idx;
    } seq_t;

    typedef struct packed {
        logic [NUM_ELEM-1:0] en;
        logic                fail;
    } out_t;

    seq_t seq_d, seq_q;
    out_t out_d, out_q;

    logic [LFSR_W-1:0]   lfsr_nxt;
    logic [TBITS-1:0]    off_raw;
    logic [NUM_ELEM-1:0] therm_w;
    logic [NUM_ELEM-1:0] rot_w;

    dem_lfsr_step #(.W(LFSR_W), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO)) u_step (
        .cur (seq_q.lfsr),
        .nxt (lfsr_nxt)
    );

    assign off_raw = lfsr_nxt[TBITS-1:0];

    // Sequencing: shift register, offset capture, code assembly
    always_comb begin
        seq_d = seq_q;
        if (conv_start) begin
            seq_d.lfsr   = lfsr_nxt;
            seq_d.offset = (off_raw >= TBITS'(NUM_ELEM)) ? off_raw - TBITS'(NUM_ELEM) : off_raw;
            seq_d.code   = '0;
            seq_d.idx    = '0;
        end else if (dec_valid && (int'(seq_q.idx) < TBITS)) begin
            for (int b = 0; b < TBITS; b++) begin
                if (int'(seq_q.idx) == TBITS - 1 - b) seq_d.code[b] = dec_bit;
            end
            seq_d.idx = seq_q.idx + IDX_W'(1);
        end
    end

    dem_therm_enc #(.NBITS(TBITS)) u_therm (
        .code  (seq_d.code),
        .therm (therm_w)
    );

    dem_rotator #(.N(NUM_ELEM), .AMT_W(TBITS)) u_rot (
        .din  (therm_w),
        .amt  (seq_d.offset),
        .dout (rot_w)
    );

    // Count check before the enables are committed
    always_comb begin
        out_d = out_q;
        if ($countones(rot_w) == int'(seq_d.code)) begin
            out_d.en   = rot_w;
            out_d.fail = 1'b0;
        end else begin
            out_d.en   = '0;
            out_d.fail = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.lfsr   <= SEED;
            seq_q.offset <= '0;
            seq_q.code   <= '0;
            seq_q.idx    <= '0;
            out_q.en     <= '0;
            out_q.fail   <= 1'b0;
        end else begin
            seq_q <= seq_d;
            out_q <= out_d;
        end
    end

    assign elem_en    = out_q.en;
    assign check_fail = out_q.fail;
endmodule

// File: rtl/dem_therm_scrambler_chk.sv
module dem_therm_scrambler_chk #(
    parameter int NUM_ELEM = 7
) (
    input logic                clk,
    input logic                rst_n,
    input logic                conv_start,
    input logic                dec_valid,
    input logic                dec_bit,
    input logic [NUM_ELEM-1:0] elem_en,
    input logic                check_fail
);
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> (elem_en == '0)); // R8

    AST_START_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && dec_valid && dec_bit) |=> ($countones(elem_en) == 0)); // R9

    AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_start |=> ((elem_en & $past(elem_en)) == $past(elem_en))); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!conv_start && !dec_valid) |=> $stable(elem_en)); // R7

    AST_ZERO_DEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!conv_start && dec_valid && !dec_bit) |=> $stable(elem_en)); // R5

    AST_NO_COUNT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        !check_fail); // R11
endmodule

bind dem_therm_scrambler dem_therm_scrambler_chk #(.NUM_ELEM(NUM_ELEM)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_start (conv_start),
    .dec_valid  (dec_valid),
    .dec_bit    (dec_bit),
    .elem_en    (elem_en),
    .check_fail (check_fail)
);

// File: tb/test_dem_therm_scrambler.sv
module test_dem_therm_scrambler;
    localparam int CLK_PERIOD = 10;
    localparam int NE = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          conv_start = 1'b0;
    logic          dec_valid = 1'b0;
    logic          dec_bit = 1'b0;
    logic [NE-1:0] elem_en;
    logic          check_fail;

    int n_chk = 0;
    int n_bad = 0;
    bit seen_raw7 = 1'b0;

    // Reference model state, built from the requirements
    logic [14:0] m_lfsr = 15'h0001;
    logic [2:0]  m_off = '0;
    logic [2:0]  m_code = '0;
    int          m_idx = 0;

    dem_therm_scrambler i_dem_therm_scrambler (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_start (conv_start),
        .dec_valid  (dec_valid),
        .dec_bit    (dec_bit),
        .elem_en    (elem_en),
        .check_fail (check_fail)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [NE-1:0] exp_en(input logic [2:0] code, input logic [2:0] off);
        logic [NE-1:0] r;
        r = '0;
        for (int i = 0; i < NE; i++)
            if (i < int'(code)) r[(i + int'(off)) % NE] = 1'b1;
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_out(input string req);
        check(elem_en == exp_en(m_code, m_off), req, elem_en, exp_en(m_code, m_off));
        check($countones(elem_en) == int'(m_code), "R2", $countones(elem_en), m_code);
        check(check_fail == 1'b0, "R11", check_fail, 0);
    endtask

    // One clock of stimulus; inputs change at the falling edge, model follows R3/R5/R6/R9/R10
    task automatic cyc(input bit st, input bit dv, input bit db);
        conv_start = st; dec_valid = dv; dec_bit = db;
        @(negedge clk);
        conv_start = 1'b0; dec_valid = 1'b0; dec_bit = 1'b0;
        if (st) begin
            m_lfsr = {m_lfsr[13:0], m_lfsr[14] ^ m_lfsr[13]};
            if (m_lfsr[2:0] == 3'd7) begin
                m_off = 3'd0;
                seen_raw7 = 1'b1;
            end else m_off = m_lfsr[2:0];
            m_code = '0;
            m_idx = 0;
        end else if (dv && m_idx < 3) begin
            m_code[2 - m_idx] = db;
            m_idx++;
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(elem_en == '0, "R1", elem_en, 0);
        check(check_fail == 1'b0, "R1", check_fail, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(elem_en == '0, "R1", elem_en, 0);
    endtask

    task automatic t_conversion(input logic [2:0] code);
        logic [NE-1:0] prev;
        cyc(1, 0, 0);
        check(elem_en == '0, "R8", elem_en, 0);
        for (int k = 2; k >= 0; k--) begin
            prev = elem_en;
            cyc(0, 1, code[k]);
            check_out("R4");
            check((elem_en & prev) == prev, "R7", elem_en, prev);
        end
        if (code == 3'd1) check(elem_en == (7'd1 << m_off), "R3", elem_en, 7'd1 << m_off);
    endtask

    task automatic t_sweep();
        for (int n = 0; n < 200; n++) t_conversion(3'(n % 8));
        check(seen_raw7, "R10", seen_raw7, 1);
    endtask

    task automatic t_extra_decisions();
        t_conversion(3'd5);
        cyc(0, 1, 1);
        check_out("R6");
        cyc(0, 1, 1);
        check(elem_en == exp_en(3'd5, m_off), "R6", elem_en, exp_en(3'd5, m_off));
    endtask

    task automatic t_start_priority();
        t_conversion(3'd7);
        cyc(1, 1, 1);
        check(elem_en == '0, "R9", elem_en, 0);
        cyc(0, 1, 1);
        check_out("R5");
        check($countones(elem_en) == 4, "R5", $countones(elem_en), 4);
        cyc(0, 1, 0);
        check_out("R5");
        cyc(0, 1, 1);
        check_out("R5");
    endtask

    task automatic t_idle_hold();
        logic [NE-1:0] snap;
        cyc(1, 0, 0);
        cyc(0, 1, 0);
        cyc(0, 1, 1);
        snap = elem_en;
        repeat (5) cyc(0, 0, 0);
        check(elem_en == snap, "R7", elem_en, snap);
        cyc(0, 1, 1);
        check_out("R7");
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        t_reset();
        t_sweep();
        t_extra_decisions();
        t_start_priority();
        t_idle_hold();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule